// File: doc/BRIEF.md
# Hybrid Coarse/Fine Pulse Width Modulator

This block produces one pulse-width-modulated output for a switching power converter. Its resolution is finer than the period of its base clock. A free-running counter on the base clock sets the switching period and the coarse part of the pulse width. Three further copies of the base clock, shifted by a quarter, a half and three quarters of a period, re-sample the coarse pulse. The two low bits of the duty word choose one of these four timings, so the falling edge of the output can be placed on any quarter-period boundary. The phase clocks are supplied from outside the block.

The duty word enters through a valid/ready port. `duty_ready` is high only in the last cycle of each period, when the counter is all-ones. A word transfers on a base-clock edge where `duty_valid` and `duty_ready` are both high. That word then controls the whole of the next period. If no word arrives, the previous word stays in use. While `duty_valid` is high and `duty_ready` is low, the sender must hold `duty_valid` high and keep `duty_data` unchanged. With the defaults (9-bit word, 7-bit counter), a 128 MHz base clock gives a 1 MHz switching frequency.

Top module: `hybrid_dpwm`

## Requirements
- R1: The coarse counter is NT-2 bits wide, steps by one on every base-clock edge and wraps from all-ones to zero. The switching period is therefore 2^(NT-2) base cycles.
- R2: `duty_ready` is high for exactly one base cycle per period: the cycle in which the counter is all-ones.
- R3: A duty word is taken only on a base-clock edge with `duty_valid` and `duty_ready` both high. It applies to every following period until the next transfer.
- R4: For a duty word D whose upper NT-2 bits H are nonzero, `pwm_o` is high for exactly D quarter base periods in each period. That is H whole cycles plus F quarters, where F is bits [1:0] of D, with 0 meaning no extra delay.
- R5: When the upper NT-2 bits of the duty word are zero, `pwm_o` stays low for the whole period, whatever the two low bits are.
- R6: The pulse rises on the base-clock edge one base cycle after the edge that took the word. `pwm_o` is low during the last quarter-period before that edge.
- R7: The fine bits are applied to the same period as the upper bits they were taken with. A tail of the previous pulse that reaches past the period boundary uses the previous fine bits.
- R8: A synchronous reset clears the counter, the held duty word, the coarse pulse and all phase-sampled copies. After reset is released, `duty_ready` first goes high 2^(NT-2)-1 base cycles later.
- R9: While `duty_valid` is high and `duty_ready` is low, the sender keeps `duty_valid` high and `duty_data` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (0 degree phase) |
| clk_ph | input | 3 | Copies of clk delayed by 1/4, 1/2 and 3/4 period (bit 0 = 1/4) |
| rst | input | 1 | Synchronous active-high reset |
| duty_valid | input | 1 | Duty word offered |
| duty_ready | output | 1 | Block accepts a duty word on this cycle |
| duty_data | input | NT | Duty word: bits [NT-1:2] coarse cycles, bits [1:0] quarter steps |
| pwm_o | output | 1 | Modulated output |

## Verification
An error in the counter or the full flag would show at once at `duty_ready`: its spacing from reset release and between pulses would differ from 127 and 128 cycles. A fault in the held word or in the coarse register changes the measured high time by whole cycles in the first period after the transfer. A fault in the fine alignment stage, a phase flop or the multiplexer changes the width by one to three quarters, and shows at the first code whose low bits are nonzero. The bench counts high time with samples spaced a quarter period apart. It checks two back-to-back periods for each word, so a lost hold value appears one period later.

// File: rtl/hdpwm_pkg.sv
package hdpwm_pkg;
  // Phase picked for the trailing edge, indexed by the duty low bits
  typedef enum logic [1:0] {
    PH_0   = 2'd0,
    PH_90  = 2'd1,
    PH_180 = 2'd2,
    PH_270 = 2'd3
  } phase_sel_e;
endpackage

// File: rtl/hdpwm_counter.sv
module hdpwm_counter #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          zero_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic          zero_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) zero_q <= 1'b0;
    else     zero_q <= full_o;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_MAX);
  assign zero_o = zero_q;

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == '0));
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R1
  zero_after_full_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> (cnt_q == '0));
endmodule

// File: rtl/hdpwm_duty_hold.sv
module hdpwm_duty_hold #(
  parameter int NT = 9,
  localparam int CW = NT - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          full_i,
  input  logic          valid_i,
  input  logic [NT-1:0] data_i,
  output logic          ready_o,
  output logic [CW-1:0] coarse_o,
  output logic [1:0]    fine_o
);
  logic [NT-1:0] hold_q;
  logic [1:0]    fine_al_q;
  logic          take;

  assign ready_o = full_i;
  assign take    = valid_i && full_i;

  always_ff @(posedge clk) begin
    if (rst)       hold_q <= '0;
    else if (take) hold_q <= data_i;
  end

  // extra stage so the fine bits switch together with the coarse pulse
  always_ff @(posedge clk) begin
    if (rst) fine_al_q <= '0;
    else     fine_al_q <= hold_q[1:0];
  end

  assign coarse_o = hold_q[NT-1:2];
  assign fine_o   = fine_al_q;

  // R3
  hold_only_on_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(hold_q));
  // R9
  sender_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !ready_o) |=> (valid_i && $stable(data_i)));
endmodule

// File: rtl/hdpwm_coarse.sv
module hdpwm_coarse #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic          zero_i,
  input  logic [CW-1:0] hi_i,
  output logic          pulse_o
);
  logic pulse_q;
  logic match;

  assign match = (cnt_i >= hi_i);

  always_ff @(posedge clk) begin
    if (rst)         pulse_q <= 1'b0;
    else if (match)  pulse_q <= 1'b0;
    else if (zero_i) pulse_q <= 1'b1;
  end

  assign pulse_o = pulse_q;

  // R6
  start_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_i && hi_i != '0) |=> pulse_q);
  // R5
  silent_when_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_i == '0) |-> !pulse_q);
  // R4
  stop_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && match) |=> !pulse_q);
endmodule

// File: rtl/hdpwm_fine.sv
module hdpwm_fine
  import hdpwm_pkg::*;
(
  input  logic       clk,
  input  logic [2:0] clk_ph,
  input  logic       rst,
  input  logic       pulse_i,
  input  logic [1:0] sel_i,
  output logic       late_o
);
  logic [2:0] dly;

  for (genvar g = 0; g < 3; g++) begin : g_ph
    logic q;
    always_ff @(posedge clk_ph[g]) begin
      if (rst) q <= 1'b0;
      else     q <= pulse_i;
    end
    assign dly[g] = q;
  end

  always_comb begin
    unique case (phase_sel_e'(sel_i))
      PH_0:    late_o = pulse_i;
      PH_90:   late_o = dly[0];
      PH_180:  late_o = dly[1];
      PH_270:  late_o = dly[2];
      default: late_o = pulse_i;
    endcase
  end

  // R8
  phase_cleared_chk: assert property (@(posedge clk)
    $past(rst) && rst |-> (dly == 3'b000));
  // R7
  no_late_without_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!pulse_i && !$past(pulse_i)) |-> (dly == 3'b000));
endmodule

// File: rtl/hybrid_dpwm.sv
module hybrid_dpwm #(
  parameter int NT = 9,
  localparam int CW = NT - 2
) (
  input  logic          clk,
  input  logic [2:0]    clk_ph,
  input  logic          rst,
  input  logic          duty_valid,
  output logic          duty_ready,
  input  logic [NT-1:0] duty_data,
  output logic          pwm_o
);
  logic [CW-1:0] cnt;
  logic          full;
  logic          zero;
  logic [CW-1:0] hi;
  logic [1:0]    fine;
  logic          coarse;
  logic          late;

  hdpwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .cnt_o(cnt), .full_o(full), .zero_o(zero)
  );

  hdpwm_duty_hold #(.NT(NT)) u_hold (
    .clk(clk), .rst(rst), .full_i(full), .valid_i(duty_valid),
    .data_i(duty_data), .ready_o(duty_ready), .coarse_o(hi), .fine_o(fine)
  );

  hdpwm_coarse #(.CW(CW)) u_coarse (
    .clk(clk), .rst(rst), .cnt_i(cnt), .zero_i(zero), .hi_i(hi),
    .pulse_o(coarse)
  );

  hdpwm_fine u_fine (
    .clk(clk), .clk_ph(clk_ph), .rst(rst), .pulse_i(coarse),
    .sel_i(fine), .late_o(late)
  );

  // dominant set from the coarse pulse, released when the chosen copy falls
  assign pwm_o = coarse | late;

  // R2
  ready_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    duty_ready |=> !duty_ready);
  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) && rst |-> (!duty_ready && !coarse));
endmodule

// File: tb/hybrid_dpwm_tb.sv
`timescale 1ns/100ps
module hybrid_dpwm_tb;
  localparam int NT  = 9;
  localparam int CW  = NT - 2;
  localparam int PER = 1 << CW;       // base cycles per switching period
  localparam int QPP = 4 * PER;       // quarter steps per period

  logic          clk = 1'b0;
  logic [2:0]    clk_ph = 3'b110;
  logic          rst = 1'b1;
  logic          duty_valid = 1'b0;
  logic          duty_ready;
  logic [NT-1:0] duty_data = '0;
  logic          pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hybrid_dpwm #(.NT(NT)) u_dut (
    .clk(clk), .clk_ph(clk_ph), .rst(rst), .duty_valid(duty_valid),
    .duty_ready(duty_ready), .duty_data(duty_data), .pwm_o(pwm_o)
  );

  // 250 MHz base clock and its quarter-period shifted copies
  initial forever #2 clk = ~clk;
  initial begin #1; forever #2 clk_ph[0] = ~clk_ph[0]; end
  initial forever #2 clk_ph[1] = ~clk_ph[1];
  initial begin #1; forever #2 clk_ph[2] = ~clk_ph[2]; end

  function automatic int exp_quarters(int code);
    if ((code >> 2) == 0) return 0;
    return code;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #0.5;
  endtask

  task automatic run_code(int code);
    int w1 = 0;
    int w2 = 0;
    int exp = exp_quarters(code);
    tick();
    duty_data  = code[NT-1:0];
    duty_valid = 1'b1;
    while (!duty_ready) tick();
    tick();                     // word taken on the edge just passed
    duty_valid = 1'b0;
    #3;
    chk(pwm_o == 1'b0, "R6 low before start", pwm_o, 0);
    for (int k = 0; k < 2 * QPP; k++) begin
      #1;
      if (k == 0) chk(pwm_o == (exp != 0), "R6 rise one cycle after transfer",
                      pwm_o, exp != 0);
      if (k < QPP) w1 += pwm_o;
      else         w2 += pwm_o;
    end
    if ((code >> 2) == 0) chk(w1 == 0, "R5 zero coarse gives no pulse", w1, 0);
    else                  chk(w1 == exp, "R4 R7 high time in quarters", w1, exp);
    chk(w2 == exp, "R3 held word reused next period", w2, exp);
  endtask

  initial begin
    int n;
    int codes[16] = '{0, 1, 2, 3, 4, 5, 6, 7, 511, 510, 509, 508, 256, 257, 258, 259};
    void'($urandom(32'd20240611));
    repeat (4) tick();
    chk(pwm_o == 1'b0, "R8 output low in reset", pwm_o, 0);
    chk(duty_ready == 1'b0, "R8 ready low in reset", duty_ready, 0);
    rst = 1'b0;
    n = 0;
    do begin tick(); n++; end while (!duty_ready && n < 1000);
    chk(n == PER - 1, "R8 R1 first ready after reset", n, PER - 1);
    tick();
    chk(duty_ready == 1'b0, "R2 ready lasts one cycle", duty_ready, 0);
    n = 1;
    while (!duty_ready && n < 1000) begin tick(); n++; end
    chk(n == PER, "R1 R2 period between ready pulses", n, PER);

    foreach (codes[i]) run_code(codes[i]);
    for (int i = 0; i < 40; i++) run_code(int'($urandom % (1 << NT)));

    // reset in the middle of a pulse
    run_code(300);
    tick();
    duty_data = 9'd400; duty_valid = 1'b1;
    while (!duty_ready) tick();
    tick(); duty_valid = 1'b0;
    repeat (20) tick();
    chk(pwm_o == 1'b1, "R4 pulse active before reset", pwm_o, 1);
    rst = 1'b1;
    tick(); tick();
    chk(pwm_o == 1'b0, "R8 reset clears output", pwm_o, 0);
    chk(duty_ready == 1'b0, "R8 reset clears ready", duty_ready, 0);
    rst = 1'b0;
    n = 0;
    do begin tick(); n++; end while (!duty_ready && n < 1000);
    chk(n == PER - 1, "R8 counter restarts from zero", n, PER - 1);
    run_code(0);
    chk(pwm_o == 1'b0, "R5 output low after zero word", pwm_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule